// File: doc/BRIEF.md
# Power Island Switch Sequencer

This block powers a chosen on-chip power island up or down in an order that is safe for the hardware. A single request carries a domain number, a direction (up or down) and a valid strobe. While the sequence runs, the block steps through the island's power switch control, its memory bank power-down fields, its output isolation control, a shared reset and a shared clock enable, with timed pauses between the steps. When the last step is done it pulses a completion flag.

Each island is described by an entry in a table that is fixed at elaboration. The entry says whether the island has a switch and isolation control and at which bit positions, which memory power-down bits belong to it, and whether the shared reset and the shared clock enable take part in its sequence. Some islands own only memory bits. A separate status bus reports the switch control bit of each island.

The timed pauses are counted in clock cycles. A frequency parameter in MHz converts the microsecond pauses into cycles. The short pause is 20 us and the long pause is 20 ms.

Top module: `pwr_island_seq`

## Requirements
- R1: After reset, the switch bit of every island that has one is 1 (bits 8, 16 and 17 of `sleep_o` with the default table). The isolation bit of every such island is 1 (bits 9, 16 and 17 of `iso_o`). Every configured memory power-down bit is 1, `bulk_rst_o` is 1, `clk_en_o` is 0, and `busy_o`, `done_o` and `err_o` are 0.
- R2: A power-down request accepted at clock edge E sets the island's switch bit at E. It sets all of the island's memory bits at E+S, where S = 20 x CLK_MHZ cycles. It sets the island's isolation bit at E+2S.
- R3: On power-down of an island configured with clocks, `clk_en_o` drops to 0 at E+2S+L, where L = 20000 x CLK_MHZ cycles. Completion happens at that same edge. Without clocks, completion happens at E+2S.
- R4: A power-up request accepted at E clears the switch bit at E and clears the island's memory bits at E+S. At E+2S the reset is asserted, at E+2S+1 isolation is cleared, at E+2S+2 the reset is released, and at E+2S+3 `clk_en_o` is set. Completion happens at E+2S+3.
- R5: `bulk_rst_o` changes only for islands configured with resets, and `clk_en_o` changes only for islands configured with clocks. For the other islands these steps keep the full sequence length but change nothing.
- R6: For an island without a switch or isolation control, `sleep_o` and `iso_o` stay unchanged. The two short pauses still take place.
- R7: A sequence changes only the memory, switch and isolation bits that belong to the selected island.
- R8: `dom_stat_o[d]` equals the switch bit of island d. It is 0 for islands without a switch control.
- R9: A request with `req_id_i` greater than or equal to N_DOM, made while idle, produces a one-cycle `err_o` pulse and changes no other output.
- R10: `busy_o` is 1 from the edge that accepts a request up to the completion edge. Requests made while `busy_o` is 1 are ignored. `done_o` is 1 for exactly the one cycle after the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| req_id_i | input | ID_W | Island number |
| req_on_i | input | 1 | 1 = power up, 0 = power down |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for a rejected island number |
| dom_stat_o | output | N_DOM | Switch bit of each island |
| sleep_o | output | 32 | Switch (sleep) control bits |
| mem_pd_o | output | 64 | Memory power-down bits (two 32-bit control words) |
| iso_o | output | 32 | Output isolation control bits |
| bulk_rst_o | output | 1 | Shared reset, active high |
| clk_en_o | output | 1 | Shared clock enable |

## Verification
The bench targets three kinds of error: the asymmetry between the two directions, the steps that a given island skips, and requests that arrive at the wrong moment. Some designs run the power-up tail in the power-down order, or wait the long pause on power-up. Such a design moves `clk_en_o` or `done_o` in the wrong cycle, and the per-cycle model catches it. Other designs touch the reset or clock for an island that does not own them, or touch the switch bits of the memory-only island. These show up as stray edges on `bulk_rst_o`, `clk_en_o` or `sleep_o`. A request made in mid-sequence, or with an island number past the table, must leave every control output alone. A design that accepts such a request starts a second sequence, and its switch bits and status drift from the model.

// File: rtl/pisq_pkg.sv
package pisq_pkg;

    localparam int SLP_W = 32;
    localparam int MEM_W = 64;
    localparam int BIT_W = $clog2(SLP_W);

    typedef struct packed {
        logic             has_top;
        logic [BIT_W-1:0] slp_bit;
        logic [BIT_W-1:0] iso_bit;
        logic [MEM_W-1:0] mem_mask;
        logic             has_rst;
        logic             has_clk;
    } dom_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_MEM,
        ST_WAIT_LAST,
        ST_CLK_HOLD,
        ST_ISO_REL,
        ST_RST_REL,
        ST_CLK_ON
    } seq_st_t;

    typedef struct packed {
        logic sleep;
        logic mem;
        logic iso;
        logic rst_set;
        logic rst_clr;
        logic clk;
    } step_t;

    function automatic dom_cfg_t mk_dom(logic top, int sb, int ib,
                                        logic [MEM_W-1:0] mask,
                                        logic r, logic c);
        dom_cfg_t e;
        e.has_top  = top;
        e.slp_bit  = BIT_W'(sb);
        e.iso_bit  = BIT_W'(ib);
        e.mem_mask = mask;
        e.has_rst  = r;
        e.has_clk  = c;
        return e;
    endfunction

    // island 0: switch/iso in distinct bits, many banks over two words, reset and clocks
    // island 1: same bit index in both controls, one 8-bit memory group
    // island 2: same bit index, one 2-bit bank
    // island 3: memory only
    localparam dom_cfg_t [3:0] DEF_CFG = {
        mk_dom(1'b0,  0,  0, 64'h0000_0000_0003_0000, 1'b0, 1'b0),
        mk_dom(1'b1, 17, 17, 64'h0000_0000_C000_0000, 1'b0, 1'b0),
        mk_dom(1'b1, 16, 16, 64'h00FF_0000_0000_0000, 1'b0, 1'b0),
        mk_dom(1'b1,  8,  9, 64'h0000_00FF_0000_FFFF, 1'b1, 1'b1)
    };

endpackage

// File: rtl/pisq_timer.sv
module pisq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)              cnt_q <= '0;
        else if (load_i)        cnt_q <= val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pisq_ctrl.sv
module pisq_ctrl
    import pisq_pkg::*;
#(
    parameter int               N_DOM    = 4,
    parameter int               ID_W     = 3,
    parameter int               CNT_W    = 16,
    parameter logic [CNT_W-1:0] SHORT_LD = '0,
    parameter logic [CNT_W-1:0] LONG_LD  = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             req_valid_i,
    input  logic [ID_W-1:0]  req_id_i,
    input  logic             req_on_i,
    input  logic             sel_has_clk_i,
    input  logic             tmr_exp_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic [ID_W-1:0]  cur_id_o,
    output logic             cur_on_o,
    output step_t            step_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    seq_st_t         st_q, st_d;
    logic [ID_W-1:0] id_q;
    logic            on_q;
    logic            accept, bad, fin;
    logic            id_ok;

    assign id_ok    = {1'b0, req_id_i} < (ID_W+1)'(N_DOM);
    assign cur_id_o = (st_q == ST_IDLE) ? req_id_i : id_q;
    assign cur_on_o = (st_q == ST_IDLE) ? req_on_i : on_q;

    always_comb begin
        st_d       = st_q;
        step_o     = '0;
        tmr_load_o = 1'b0;
        tmr_val_o  = SHORT_LD;
        accept     = 1'b0;
        bad        = 1'b0;
        fin        = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (id_ok) begin
                        accept       = 1'b1;
                        step_o.sleep = 1'b1;
                        tmr_load_o   = 1'b1;
                        st_d         = ST_WAIT_MEM;
                    end else begin
                        bad = 1'b1;
                    end
                end
            end
            ST_WAIT_MEM: begin
                if (tmr_exp_i) begin
                    step_o.mem = 1'b1;
                    tmr_load_o = 1'b1;
                    st_d       = ST_WAIT_LAST;
                end
            end
            ST_WAIT_LAST: begin
                if (tmr_exp_i) begin
                    if (!on_q) begin
                        step_o.iso = 1'b1;
                        if (sel_has_clk_i) begin
                            tmr_load_o = 1'b1;
                            tmr_val_o  = LONG_LD;
                            st_d       = ST_CLK_HOLD;
                        end else begin
                            fin  = 1'b1;
                            st_d = ST_IDLE;
                        end
                    end else begin
                        step_o.rst_set = 1'b1;
                        st_d           = ST_ISO_REL;
                    end
                end
            end
            ST_CLK_HOLD: begin
                if (tmr_exp_i) begin
                    step_o.clk = 1'b1;
                    fin        = 1'b1;
                    st_d       = ST_IDLE;
                end
            end
            ST_ISO_REL: begin
                step_o.iso = 1'b1;
                st_d       = ST_RST_REL;
            end
            ST_RST_REL: begin
                step_o.rst_clr = 1'b1;
                st_d           = ST_CLK_ON;
            end
            ST_CLK_ON: begin
                step_o.clk = 1'b1;
                fin        = 1'b1;
                st_d       = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= ST_IDLE;
            id_q   <= '0;
            on_q   <= 1'b0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_o <= fin;
            err_o  <= bad;
            if (accept) begin
                id_q   <= req_id_i;
                on_q   <= req_on_i;
                busy_o <= 1'b1;
            end else if (fin) begin
                busy_o <= 1'b0;
            end
        end
    end

    assert_done_ends_busy_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (!busy_o && $past(busy_o)));
    assert_err_when_idle_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |-> (!busy_o && !$past(busy_o)));
    assert_flags_excl_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({done_o, err_o, $rose(busy_o)}));
endmodule

// File: rtl/pisq_apply.sv
module pisq_apply
    import pisq_pkg::*;
#(
    parameter int                   N_DOM = 4,
    parameter dom_cfg_t [N_DOM-1:0] CFG   = DEF_CFG
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  step_t            step_i,
    input  logic             on_i,
    input  dom_cfg_t         cfg_i,
    output logic [SLP_W-1:0] sleep_o,
    output logic [SLP_W-1:0] iso_o,
    output logic [MEM_W-1:0] mem_o,
    output logic             rst_o,
    output logic             clk_en_o,
    output logic [N_DOM-1:0] stat_o
);
    logic [SLP_W-1:0] init_slp, init_iso;
    logic [MEM_W-1:0] init_mem;

    always_comb begin
        init_slp = '0;
        init_iso = '0;
        init_mem = '0;
        for (int d = 0; d < N_DOM; d++) begin
            if (CFG[d].has_top) begin
                init_slp[CFG[d].slp_bit] = 1'b1;
                init_iso[CFG[d].iso_bit] = 1'b1;
            end
            init_mem = init_mem | CFG[d].mem_mask;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sleep_o  <= init_slp;
            iso_o    <= init_iso;
            mem_o    <= init_mem;
            rst_o    <= 1'b1;
            clk_en_o <= 1'b0;
        end else begin
            if (step_i.sleep && cfg_i.has_top) sleep_o[cfg_i.slp_bit] <= !on_i;
            if (step_i.iso && cfg_i.has_top)   iso_o[cfg_i.iso_bit]   <= !on_i;
            if (step_i.mem)
                mem_o <= on_i ? (mem_o & ~cfg_i.mem_mask) : (mem_o | cfg_i.mem_mask);
            if (step_i.rst_set && cfg_i.has_rst) rst_o <= 1'b1;
            if (step_i.rst_clr && cfg_i.has_rst) rst_o <= 1'b0;
            if (step_i.clk && cfg_i.has_clk)     clk_en_o <= on_i;
        end
    end

    for (genvar d = 0; d < N_DOM; d++) begin : g_stat
        if (CFG[d].has_top) begin : g_top
            assign stat_o[d] = sleep_o[CFG[d].slp_bit];
        end else begin : g_mem_only
            assign stat_o[d] = 1'b0;
        end
    end
endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq
    import pisq_pkg::*;
#(
    parameter int                   N_DOM    = 4,
    parameter int                   ID_W     = 3,
    parameter int                   CLK_MHZ  = 1,
    parameter int                   SHORT_US = 20,
    parameter int                   LONG_US  = 20000,
    parameter dom_cfg_t [N_DOM-1:0] CFG      = DEF_CFG
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             req_valid_i,
    input  logic [ID_W-1:0]  req_id_i,
    input  logic             req_on_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [N_DOM-1:0] dom_stat_o,
    output logic [31:0]      sleep_o,
    output logic [63:0]      mem_pd_o,
    output logic [31:0]      iso_o,
    output logic             bulk_rst_o,
    output logic             clk_en_o
);
    localparam int SHORT_CYC = SHORT_US * CLK_MHZ;
    localparam int LONG_CYC  = LONG_US * CLK_MHZ;
    localparam int CNT_W     = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);

    logic             tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_val;
    logic [ID_W-1:0]  cur_id;
    logic             cur_on;
    step_t            step;
    dom_cfg_t         cur_cfg;

    always_comb begin
        cur_cfg = '0;
        for (int d = 0; d < N_DOM; d++)
            if (ID_W'(d) == cur_id) cur_cfg = CFG[d];
    end

    pisq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_exp)
    );

    pisq_ctrl #(
        .N_DOM(N_DOM), .ID_W(ID_W), .CNT_W(CNT_W),
        .SHORT_LD(SHORT_LD), .LONG_LD(LONG_LD)
    ) u_ctrl (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .req_valid_i   (req_valid_i),
        .req_id_i      (req_id_i),
        .req_on_i      (req_on_i),
        .sel_has_clk_i (cur_cfg.has_clk),
        .tmr_exp_i     (tmr_exp),
        .tmr_load_o    (tmr_load),
        .tmr_val_o     (tmr_val),
        .cur_id_o      (cur_id),
        .cur_on_o      (cur_on),
        .step_o        (step),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .err_o         (err_o)
    );

    pisq_apply #(.N_DOM(N_DOM), .CFG(CFG)) u_apply (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .step_i   (step),
        .on_i     (cur_on),
        .cfg_i    (cur_cfg),
        .sleep_o  (sleep_o),
        .iso_o    (iso_o),
        .mem_o    (mem_pd_o),
        .rst_o    (bulk_rst_o),
        .clk_en_o (clk_en_o),
        .stat_o   (dom_stat_o)
    );

    assert_sleep_on_accept_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(sleep_o) |-> $rose(busy_o));
    assert_mem_in_seq_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(mem_pd_o) |-> (busy_o && $past(busy_o)));
    assert_iso_in_seq_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(iso_o) |-> $past(busy_o));
    assert_clk_off_done_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(clk_en_o) |-> done_o);
    assert_rst_rel_busy_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(bulk_rst_o) |-> busy_o);
    assert_clk_on_done_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(clk_en_o) |-> (done_o && !bulk_rst_o));
endmodule

// File: tb/pwr_island_seq_test.sv
module pwr_island_seq_test;
    localparam int PERIOD = 10;
    localparam int S = 20;
    localparam int L = 20000;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_id = '0;
    logic        req_on = 1'b0;
    logic        busy_o, done_o, err_o, bulk_rst_o, clk_en_o;
    logic [3:0]  dom_stat_o;
    logic [31:0] sleep_o, iso_o;
    logic [63:0] mem_pd_o;

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    always #(PERIOD/2) clk = ~clk;

    pwr_island_seq uut (
        .clk_i(clk), .rst_i(rst), .req_valid_i(req_valid), .req_id_i(req_id),
        .req_on_i(req_on), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .dom_stat_o(dom_stat_o), .sleep_o(sleep_o), .mem_pd_o(mem_pd_o),
        .iso_o(iso_o), .bulk_rst_o(bulk_rst_o), .clk_en_o(clk_en_o)
    );

    // bench view of the island table
    bit          b_top [N] = '{1, 1, 1, 0};
    int          b_slp [N] = '{8, 16, 17, 0};
    int          b_iso [N] = '{9, 16, 17, 0};
    logic [63:0] b_mem [N] = '{64'h0000_00FF_0000_FFFF, 64'h00FF_0000_0000_0000,
                              64'h0000_0000_C000_0000, 64'h0000_0000_0003_0000};
    bit          b_rst [N] = '{1, 0, 0, 0};
    bit          b_clk [N] = '{1, 0, 0, 0};

    localparam logic [31:0] R_SLP = 32'h0003_0100;
    localparam logic [31:0] R_ISO = 32'h0003_0200;
    localparam logic [63:0] R_MEM = 64'h00FF_00FF_C003_FFFF;

    logic [31:0] e_slp, e_iso;
    logic [63:0] e_mem;
    logic        e_rst, e_clk, e_busy, e_done, e_err;
    int          m_id, m_t;
    bit          m_on;

    always @(posedge clk) begin
        if (rst) begin
            e_slp <= R_SLP; e_iso <= R_ISO; e_mem <= R_MEM;
            e_rst <= 1'b1;  e_clk <= 1'b0;
            e_busy <= 1'b0; e_done <= 1'b0; e_err <= 1'b0;
            m_id <= 0; m_t <= 0; m_on <= 0;
        end else begin
            e_done <= 1'b0;
            e_err  <= 1'b0;
            if (!e_busy) begin
                if (req_valid) begin
                    if (int'(req_id) >= N) e_err <= 1'b1;
                    else begin
                        m_id <= int'(req_id); m_on <= req_on; m_t <= 1; e_busy <= 1'b1;
                        if (b_top[req_id]) e_slp[b_slp[req_id]] <= !req_on;
                    end
                end
            end else begin
                m_t <= m_t + 1;
                if (m_t == S)
                    e_mem <= m_on ? (e_mem & ~b_mem[m_id]) : (e_mem | b_mem[m_id]);
                if (m_t == 2*S) begin
                    if (!m_on) begin
                        if (b_top[m_id]) e_iso[b_iso[m_id]] <= 1'b1;
                        if (!b_clk[m_id]) begin e_busy <= 1'b0; e_done <= 1'b1; end
                    end else if (b_rst[m_id]) e_rst <= 1'b1;
                end
                if (m_on && m_t == 2*S+1 && b_top[m_id]) e_iso[b_iso[m_id]] <= 1'b0;
                if (m_on && m_t == 2*S+2 && b_rst[m_id]) e_rst <= 1'b0;
                if (m_on && m_t == 2*S+3) begin
                    if (b_clk[m_id]) e_clk <= 1'b1;
                    e_busy <= 1'b0; e_done <= 1'b1;
                end
                if (!m_on && b_clk[m_id] && m_t == 2*S+L) begin
                    e_clk <= 1'b0; e_busy <= 1'b0; e_done <= 1'b1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 R4 R6 sleep", 64'(sleep_o), 64'(e_slp));
            chk("R2 R4 R6 iso", 64'(iso_o), 64'(e_iso));
            chk("R7 mem", mem_pd_o, e_mem);
            chk("R5 rst", 64'(bulk_rst_o), 64'(e_rst));
            chk("R3 clk", 64'(clk_en_o), 64'(e_clk));
            chk("R10 busy", 64'(busy_o), 64'(e_busy));
            chk("R10 done", 64'(done_o), 64'(e_done));
            chk("R9 err", 64'(err_o), 64'(e_err));
            chk("R8 status", 64'(dom_stat_o),
                64'({1'b0, e_slp[17], e_slp[16], e_slp[8]}));
        end
    end

    task automatic run_req(input int id, input bit on, output int n);
        @(negedge clk);
        req_valid = 1'b1; req_id = 3'(id); req_on = on;
        n = 0;
        while (n < 30000) begin
            @(negedge clk);
            n++;
            if (n == 1) req_valid = 1'b0;
            if (done_o) break;
        end
    endtask

    task automatic finish_up();
        if (!reported) begin
            reported = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 sleep", 64'(sleep_o), 64'(R_SLP));
        chk("R1 iso", 64'(iso_o), 64'(R_ISO));
        chk("R1 mem", mem_pd_o, R_MEM);
        chk("R1 rst clk busy", {61'd0, bulk_rst_o, clk_en_o, busy_o}, 64'h4);

        // R6 memory-only island up: waits kept, sleep/iso untouched
        run_req(3, 1'b1, n);
        chk("R6 latency", 64'(n), 64'(2*S+4));
        chk("R6 sleep", 64'(sleep_o), 64'(R_SLP));
        chk("R6 iso", 64'(iso_o), 64'(R_ISO));

        // R4 island with reset and clocks up
        run_req(0, 1'b1, n);
        chk("R4 latency", 64'(n), 64'(2*S+4));
        chk("R4 clk on", 64'(clk_en_o), 64'd1);
        chk("R8 stat d0", 64'(dom_stat_o[0]), 64'd0);

        // R9 out-of-range number while idle
        run_req(5, 1'b1, n);
        chk("R9 no busy", 64'(busy_o), 64'd0);

        // R10 request while busy is ignored
        fork
            run_req(1, 1'b1, n);
            begin
                repeat (6) @(negedge clk);
                req_valid = 1'b1; req_id = 3'd2; req_on = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
            end
        join
        chk("R10 ignored d2", 64'(sleep_o[17]), 64'd1);
        chk("R5 rst kept", 64'(bulk_rst_o), 64'd0);

        run_req(2, 1'b1, n);
        chk("R8 stat d2", 64'(dom_stat_o[2]), 64'd0);

        // R2 power-down without clocks
        run_req(2, 1'b0, n);
        chk("R2 latency", 64'(n), 64'(2*S+1));
        chk("R7 d1 bank kept", mem_pd_o[55:48], 64'd0);

        // R3 power-down with clocks uses the long pause
        run_req(0, 1'b0, n);
        chk("R3 latency", 64'(n), 64'(2*S+L+1));
        chk("R3 clk off", 64'(clk_en_o), 64'd0);

        run_req(3, 1'b0, n);
        chk("R6 down latency", 64'(n), 64'(2*S+1));
        run_req(1, 1'b0, n);
        run_req(0, 1'b1, n);
        chk("R4 again", 64'(n), 64'(2*S+4));
        run_req(0, 1'b0, n);
        chk("R1 back to start", mem_pd_o, R_MEM);
        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule